// File: doc/BRIEF.md
# Latency Pulse Duty-Cycle Meter

This block estimates how full a phase compensation FIFO is, and so its latency, to a fraction of a word. The FIFO produces a pulse that is high for a share of time equal to its fill divided by its depth. The meter samples that pulse with a free-running sample clock. The sample clock must differ in frequency from the parallel data clock; typical ratios are 128/127 or 64/127 of it, and it may run up to 262 MHz. Because of the offset, successive samples sweep all phase relationships between the two clocks. Over a long window the share of high samples is the average duty cycle of the pulse.

The pulse is asynchronous to the sample clock. It passes through a two-stage synchronizer before any sample is counted. A start request first flushes the synchronizer and then counts a window of 2^k samples. For each window the meter reports the number of high samples and the total number of samples, then freezes both counts and raises a done flag. Host software computes the fill as depth × high / total.

Top module: `lat_duty_meter`

## Requirements
- R1: Out of reset, done is 0 and high_cnt and total_cnt are 0.
- R2: In the cycle after an edge that samples start=1, done is 0 and both counts are 0. This applies in any state, so start also restarts a window that is running or complete.
- R3: The window length is N = 2^k. k is win_log2 as sampled on the start edge. A change of win_log2 after that edge has no effect on the window under way.
- R4: A win_log2 below LOG_MIN gives a window of 2^LOG_MIN samples. A win_log2 above LOG_MAX gives a window of 2^LOG_MAX samples.
- R5: The counted samples are the levels of pulse_async at the N rising edges that follow the start edge, each delayed by the two synchronizer stages. total_cnt ends at N and high_cnt ends at the number of those levels that were 1. Levels present at or before the start edge are never counted.
- R6: done rises after exactly N+2 rising edges following the start edge, and is 0 one edge earlier.
- R7: While done is 1 and start is 0, done stays 1 and both counts hold their values, whatever pulse_async does.
- R8: A start issued while a window is running, or after one has completed, begins a fresh window. Counts from the earlier window do not carry over.
- R9: Each count saturates at 2^CNT_W−1 and does not wrap.
- R10: high_cnt never exceeds total_cnt.
- R11: Before the first start, toggling pulse_async leaves both counts at 0 and done at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Free-running sample clock, offset in frequency from the data clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_smp |
| pulse_async | input | 1 | Latency pulse from the FIFO, asynchronous to clk_smp |
| start | input | 1 | Request to start a new measurement window |
| win_log2 | input | SEL_W ($clog2(LOG_MAX+1), default 5) | Base-2 logarithm of the window length |
| done | output | 1 | High when the window is complete and the counts are final |
| high_cnt | output | CNT_W (default 21) | Number of counted samples that were high |
| total_cnt | output | CNT_W (default 21) | Number of samples counted |

## Verification
The bench builds two copies of the meter with LOG_MAX lowered to 12, so a request above the ceiling clamps to a 4096-sample window that completes quickly. One copy keeps CNT_W at 21 and checks exact counts. The other uses CNT_W of 10, so 1024- and 2048-sample windows drive both counts into saturation. Random pulse densities, plus all-ones, all-zeros and alternating patterns, exercise the exclusion of levels around the start edge and the exact edge on which done rises.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FLUSH,
      ST_RUN,
      ST_HOLD
   } meter_state_t;

   // Limit a requested log2 window length to the supported range.
   function automatic int unsigned clamp_log(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
      if (req < lo)      return lo;
      else if (req > hi) return hi;
      else               return req;
   endfunction

endpackage

// File: rtl/ldm_sync.sv
module ldm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ldm_sat_ctr.sv
module ldm_sat_ctr #(
   parameter int W        = 21,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   logic step;

   generate
      if (SATURATE) begin : g_sat
         assign step = inc && !(&cnt);
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
   import ldm_pkg::*;
#(
   parameter int LOG_MIN = 10,
   parameter int LOG_MAX = 20,
   parameter int SEL_W   = 5,
   parameter int STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] win_log2,
   output logic             run,
   output logic             done
);
   localparam int WC_W = LOG_MAX + 1;
   localparam int FC_W = $clog2(STAGES + 1);

   meter_state_t       state;
   logic [WC_W-1:0]    wcnt;
   logic [WC_W-1:0]    wlen;
   logic [FC_W-1:0]    fcnt;
   int unsigned        lg_eff;

   always_comb lg_eff = clamp_log(32'(win_log2), LOG_MIN, LOG_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         wcnt  <= '0;
         wlen  <= '0;
         fcnt  <= '0;
      end else if (start) begin
         state <= ST_FLUSH;
         wcnt  <= '0;
         fcnt  <= '0;
         wlen  <= WC_W'(1) << lg_eff;
      end else begin
         unique case (state)
            ST_FLUSH: begin
               if (fcnt == FC_W'(STAGES - 1)) state <= ST_RUN;
               fcnt <= fcnt + 1'b1;
            end
            ST_RUN: begin
               wcnt <= wcnt + 1'b1;
               if (wcnt + 1'b1 == wlen) state <= ST_HOLD;
            end
            default: ;
         endcase
      end
   end

   assign run  = (state == ST_RUN);
   assign done = (state == ST_HOLD);
endmodule

// File: rtl/lat_duty_meter.sv
module lat_duty_meter #(
   parameter int CNT_W       = 21,
   parameter int LOG_MIN     = 10,
   parameter int LOG_MAX     = 20,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(LOG_MAX + 1)
) (
   input  logic             clk_smp,
   input  logic             rst_n,
   input  logic             pulse_async,
   input  logic             start,
   input  logic [SEL_W-1:0] win_log2,
   output logic             done,
   output logic [CNT_W-1:0] high_cnt,
   output logic [CNT_W-1:0] total_cnt
);
   generate
      if (LOG_MIN < 1 || LOG_MIN > LOG_MAX) begin : g_bad_range
         $error("lat_duty_meter: LOG_MIN must lie in 1..LOG_MAX");
      end
      if (CNT_W < 1) begin : g_bad_width
         $error("lat_duty_meter: CNT_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lat_duty_meter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic pulse_s;
   logic run;

   ldm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_smp),
      .rst_n (rst_n),
      .d     (pulse_async),
      .q     (pulse_s)
   );

   ldm_ctrl #(
      .LOG_MIN (LOG_MIN),
      .LOG_MAX (LOG_MAX),
      .SEL_W   (SEL_W),
      .STAGES  (SYNC_STAGES)
   ) u_ctrl (
      .clk      (clk_smp),
      .rst_n    (rst_n),
      .start    (start),
      .win_log2 (win_log2),
      .run      (run),
      .done     (done)
   );

   ldm_sat_ctr #(.W(CNT_W), .SATURATE(1'b1)) u_total (
      .clk   (clk_smp),
      .rst_n (rst_n),
      .clr   (start),
      .inc   (run),
      .cnt   (total_cnt)
   );

   ldm_sat_ctr #(.W(CNT_W), .SATURATE(1'b1)) u_high (
      .clk   (clk_smp),
      .rst_n (rst_n),
      .clr   (start),
      .inc   (run && pulse_s),
      .cnt   (high_cnt)
   );
endmodule

// File: rtl/ldm_chk.sv
module ldm_chk #(
   parameter int CNT_W = 21
) (
   input logic             clk_smp,
   input logic             rst_n,
   input logic             start,
   input logic             done,
   input logic [CNT_W-1:0] high_cnt,
   input logic [CNT_W-1:0] total_cnt
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R2
   start_clears_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
      start |=> (!done && total_cnt == '0 && high_cnt == '0));

   // R7
   hold_frozen_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(total_cnt) && $stable(high_cnt)));

   // R10
   high_le_total_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
      high_cnt <= total_cnt);

   // R5
   single_step_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !start |=> (total_cnt == $past(total_cnt) || total_cnt == $past(total_cnt) + 1'b1));

   // R9
   sat_hold_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (!start && total_cnt == TOP) |=> total_cnt == TOP);
endmodule

bind lat_duty_meter ldm_chk #(.CNT_W(CNT_W)) u_ldm_chk (
   .clk_smp   (clk_smp),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .high_cnt  (high_cnt),
   .total_cnt (total_cnt)
);

// File: tb/lat_duty_meter_test.sv
`timescale 1ns/1ps
module lat_duty_meter_test;
   localparam int CW      = 21;
   localparam int CW_SAT  = 10;
   localparam int LMIN    = 10;
   localparam int LMAX    = 12;
   localparam int SW      = $clog2(LMAX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse = 1'b0;
   logic start = 1'b0;
   logic [SW-1:0] win = '0;
   logic done, done_s;
   logic [CW-1:0] hi_c, tot_c;
   logic [CW_SAT-1:0] hi_s, tot_s;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lat_duty_meter #(.CNT_W(CW), .LOG_MIN(LMIN), .LOG_MAX(LMAX)) uut (
      .clk_smp(clk), .rst_n(rst_n), .pulse_async(pulse), .start(start),
      .win_log2(win), .done(done), .high_cnt(hi_c), .total_cnt(tot_c));

   lat_duty_meter #(.CNT_W(CW_SAT), .LOG_MIN(LMIN), .LOG_MAX(LMAX)) uut_sat (
      .clk_smp(clk), .rst_n(rst_n), .pulse_async(pulse), .start(start),
      .win_log2(win), .done(done_s), .high_cnt(hi_s), .total_cnt(tot_s));

   function automatic int eff_len(input int lg);
      int l = lg;
      if (l < LMIN) l = LMIN;
      if (l > LMAX) l = LMAX;
      return 1 << l;
   endfunction

   function automatic longint sat_val(input longint v, input int w);
      longint top = (longint'(1) << w) - 1;
      return (v > top) ? top : v;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int mode, input int j, input int dens);
      case (mode)
         1: return 1'b1;
         2: return 1'b0;
         3: return j[0];
         default: return (($urandom % 100) < dens);
      endcase
   endfunction

   // Full window: start, drive N levels, check done edge, counts, freeze.
   task automatic do_window(input int lg, input int mode, input int dens, input logic pre);
      int n = eff_len(lg);
      longint hcount = 0;
      longint t0, h0, ts0, hs0;
      @(negedge clk);
      win = SW'(lg);
      start = 1'b1;
      pulse = pre;
      @(negedge clk);
      start = 1'b0;
      // R2: cleared after start edge
      check("R2 total after start", tot_c, 0);
      check("R2 done after start", done, 0);
      for (int j = 0; j < n; j++) begin
         logic p = pick(mode, j, dens);
         pulse = p;
         hcount += p;
         if (j == 7) win = SW'($urandom % (1 << SW)); // R3: change ignored
         @(negedge clk);
      end
      pulse = pre;
      @(negedge clk);
      // R6: not yet done one edge early
      check("R6 done one edge early", done, 0);
      pulse = ~pre;
      @(negedge clk);
      check("R6 done on time", done, 1);
      check("R3 R4 R5 total", tot_c, n);
      check("R5 high", hi_c, hcount);
      check("R9 total saturated", tot_s, sat_val(n, CW_SAT));
      check("R9 high saturated", hi_s, sat_val(hcount, CW_SAT));
      t0 = tot_c; h0 = hi_c; ts0 = tot_s; hs0 = hi_s;
      for (int k = 0; k < 6; k++) begin
         pulse = ~pulse;
         @(negedge clk);
      end
      // R7: frozen while done
      check("R7 done held", done, 1);
      check("R7 total frozen", tot_c, t0);
      check("R7 high frozen", hi_c, h0);
      check("R7 sat high frozen", hi_s, hs0);
      check("R7 sat total frozen", tot_s, ts0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd7319));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 done in reset", done, 0);
      check("R1 total in reset", tot_c, 0);
      rst_n = 1'b1;
      // R11: idle pulse activity is ignored
      for (int k = 0; k < 20; k++) begin
         pulse = ~pulse;
         @(negedge clk);
      end
      check("R11 idle total", tot_c, 0);
      check("R11 idle high", hi_c, 0);
      check("R11 idle done", done, 0);

      // Directed corners
      do_window(10, 2, 0, 1'b1);   // R5: all zero, pre-start level high excluded
      do_window(10, 1, 0, 1'b0);   // R5/R9: all ones
      do_window(3, 3, 0, 1'b1);    // R4: below floor -> 1024
      do_window(15, 0, 40, 1'b0);  // R4: above ceiling -> 4096

      // R8: restart mid-run
      @(negedge clk);
      win = SW'(11);
      start = 1'b1;
      pulse = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      check("R8 midrun counting", tot_c > 0, 1);
      do_window(11, 0, 70, 1'b1);  // R8: fresh counts after restart

      // Random windows
      for (int r = 0; r < 4; r++) begin
         int lg = (($urandom % 2) == 0) ? 10 : 11;
         do_window(lg, 0, int'($urandom % 101), 1'($urandom));
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule